// File: doc/BRIEF.md
# Serial Receive Queue with Status Flags

This block buffers received characters for a memory-mapped serial port. The receive side offers entries of twelve bits: an eight-bit character plus four error bits above it. The host takes entries out one at a time with a pop strobe. A mode input picks the depth while the block runs. With the mode input high the buffer is a 16-entry circular queue. With it low the buffer is a single holding slot. Any change of the mode input empties the buffer.

The block reports empty and full flags and raises a receive interrupt once a character is waiting. Each pop also latches the error bits of the popped entry into a status output. A break-event input stores a dedicated break entry: zero character bits with bit 10 set.

An occupancy state machine drives the flags. It has three states: ST_EMPTY (no entries), ST_PART (some entries, but fewer than the capacity) and ST_FULL (entries equal the capacity). The transitions are:
- ST_EMPTY to ST_PART on a push in queue mode.
- ST_EMPTY to ST_FULL on a push in single mode.
- ST_PART to ST_FULL on the push that fills all 16 slots.
- ST_FULL to ST_PART on a pop in queue mode.
- ST_FULL to ST_EMPTY on a pop in single mode, or on a flush.
- ST_PART to ST_EMPTY on the pop that takes the last entry, or on a flush.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset `rx_empty`=1, `rx_full`=0, `rx_irq`=0, `push_ready`=1, `pop_data`=0 and `rx_status`=0.
- R2: With `fifo_en`=1 the buffer holds up to 16 entries and returns them in arrival order. `rx_full` rises and `push_ready` falls on the edge that stores the 16th entry.
- R3: With `fifo_en`=0 the buffer holds a single entry. `rx_full`=1 and `push_ready`=0 after one push.
- R4: A push offered while `push_ready`=0 is dropped. It changes neither the count nor the stored contents nor any flag.
- R5: A pop loads the head entry into `pop_data` on that clock edge. It also loads bits 11:8 of that entry into `rx_status`. Both outputs hold their value between pops.
- R6: A pop from an empty buffer returns the entry stored at the current read position. It moves no pointer, and `rx_empty` stays 1.
- R7: `rx_irq` rises when a push makes the count equal to 1, which is the trigger level. It falls when a pop makes the count 0.
- R8: `brk_evt` stores the entry 12'h400. If `push_valid` is high in the same cycle, the break entry wins and the pushed character is dropped.
- R9: In the first cycle that `fifo_en` differs from its registered copy, the count and read position are reset to 0. In that cycle `rx_empty` becomes 1 and `rx_full` and `rx_irq` become 0. A push or pop in that cycle is ignored.
- R10: The write slot is the read position plus the count, modulo 16. Entries therefore stay in order across the wrap from slot 15 to slot 0.
- R11: A push and a pop accepted in the same cycle with a non-empty, non-full buffer leave the count and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding slot |
| push_valid | input | 1 | Receive side offers an entry |
| push_data | input | 12 | Entry: bits 7:0 character, bits 11:8 error flags |
| push_ready | output | 1 | Buffer can take an entry this cycle |
| brk_evt | input | 1 | Break detected; stores 12'h400 |
| pop | input | 1 | Host read strobe |
| pop_data | output | 12 | Last popped entry |
| rx_status | output | 4 | Error bits of the last popped entry |
| rx_empty | output | 1 | No entries held |
| rx_full | output | 1 | Entries equal the current capacity |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A wrong count or read position shows up at the ports quickly. On the edge of the faulty push or pop, the flags or `push_ready` take the wrong value. At the latest, the next pop returns an entry out of order. A stale read position after a flush is exposed by a pop on the empty buffer, which must return slot 0. A lost interrupt update is visible on `rx_irq` right after the edge of the push or pop that should have changed it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } occ_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH   = 16,
    parameter int ENTRY_W = 12,
    parameter int PTR_W   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [PTR_W-1:0]   wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [PTR_W-1:0]   rd_addr,
    output logic [ENTRY_W-1:0] rd_data
);
    logic [ENTRY_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push_ready,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [PTR_W-1:0] rd_addr,
    output logic             pop_take,
    output logic             empty,
    output logic             full,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CAP_Q   = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CAP_S   = CNT_W'(1);
    localparam logic [CNT_W-1:0] TRIG_C  = CNT_W'(TRIG);
    localparam logic [CNT_W-1:0] TRIG_M1 = CNT_W'(TRIG - 1);
    localparam logic [PTR_W:0]   DEPTH_W = (PTR_W+1)'(DEPTH);

    logic             mode_q;
    logic [PTR_W-1:0] rd_pos_q, rd_pos_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cap_now, cap_q;
    logic             irq_q, irq_d;
    occ_t             state_q, state_d;
    logic             flush, do_push, do_adv;
    logic [PTR_W:0]   slot_sum, slot_wrap, pos_inc;

    assign flush      = (fifo_en != mode_q);
    assign cap_now    = fifo_en ? CAP_Q : CAP_S;
    assign cap_q      = mode_q ? CAP_Q : CAP_S;
    assign push_ready = !flush && (cnt_q < cap_now);
    assign do_push    = push_req && push_ready;
    assign pop_take   = pop_req && !flush;
    assign do_adv     = pop_take && (cnt_q != '0);

    // write slot: read position plus count, wrapped modulo DEPTH
    assign slot_sum  = {1'b0, rd_pos_q} + (PTR_W+1)'(cnt_q);
    assign slot_wrap = (slot_sum >= DEPTH_W) ? slot_sum - DEPTH_W : slot_sum;
    assign wr_addr   = slot_wrap[PTR_W-1:0];
    assign wr_en     = do_push;
    assign rd_addr   = rd_pos_q;
    assign pos_inc   = {1'b0, rd_pos_q} + (PTR_W+1)'(1);

    always_comb begin
        cnt_d    = cnt_q;
        rd_pos_d = rd_pos_q;
        irq_d    = irq_q;
        if (flush) begin
            cnt_d    = '0;
            rd_pos_d = '0;
            irq_d    = 1'b0;
        end else begin
            cnt_d = cnt_q + CNT_W'(do_push) - CNT_W'(do_adv);
            if (do_adv)
                rd_pos_d = (pos_inc >= DEPTH_W) ? '0 : pos_inc[PTR_W-1:0];
            if (do_push && !do_adv && cnt_d == TRIG_C)
                irq_d = 1'b1;
            else if (do_adv && !do_push && cnt_d == TRIG_M1)
                irq_d = 1'b0;
        end
        if (cnt_d == '0)          state_d = ST_EMPTY;
        else if (cnt_d == cap_now) state_d = ST_FULL;
        else                       state_d = ST_PART;
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_EMPTY;
            mode_q   <= 1'b0;
            rd_pos_q <= '0;
            cnt_q    <= '0;
            irq_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            mode_q   <= fifo_en;
            rd_pos_q <= rd_pos_d;
            cnt_q    <= cnt_d;
            irq_q    <= irq_d;
        end
    end

    // output process
    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (state_q)
            ST_EMPTY: empty = 1'b1;
            ST_PART:  ;
            ST_FULL:  full  = 1'b1;
            default:  empty = 1'b1;
        endcase
    end
    assign irq = irq_q;

    // R2 R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= cap_q);

    // R2
    full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (cnt_q == cap_q));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt_q == '0 && rd_pos_q == '0 && !irq_q));

    // R4
    drop_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !push_ready && !pop_req && !flush)
            |=> ($stable(cnt_q) && $stable(rd_pos_q)));

    generate
        if (TRIG == 1) begin : g_trig1
            // R7
            irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq_q == (cnt_q != '0));
        end
    endgenerate
endmodule

// File: rtl/rxq_stat.sv
module rxq_stat #(
    parameter int ENTRY_W = 12,
    parameter int DATA_W  = 8,
    parameter int FLAG_W  = ENTRY_W - DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic [ENTRY_W-1:0] entry,
    output logic [ENTRY_W-1:0] pop_data,
    output logic [FLAG_W-1:0]  status
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pop_data <= '0;
            status   <= '0;
        end else if (take) begin
            pop_data <= entry;
            status   <= entry[ENTRY_W-1:DATA_W];
        end
    end

    // R5
    hold_between_pops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(pop_data) && $stable(status)));
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
    parameter int DEPTH   = 16,
    parameter int DATA_W  = 8,
    parameter int FLAG_W  = 4,
    parameter int TRIG    = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fifo_en,
    input  logic                     push_valid,
    input  logic [DATA_W+FLAG_W-1:0] push_data,
    output logic                     push_ready,
    input  logic                     brk_evt,
    input  logic                     pop,
    output logic [DATA_W+FLAG_W-1:0] pop_data,
    output logic [FLAG_W-1:0]        rx_status,
    output logic                     rx_empty,
    output logic                     rx_full,
    output logic                     rx_irq
);
    localparam int ENTRY_W = DATA_W + FLAG_W;
    localparam int PTR_W   = $clog2(DEPTH);
    localparam logic [ENTRY_W-1:0] BRK_CODE = ENTRY_W'(1) << (DATA_W + 2);

    logic               wr_en, pop_take;
    logic [PTR_W-1:0]   wr_addr, rd_addr;
    logic [ENTRY_W-1:0] wr_data, rd_data;

    assign wr_data = brk_evt ? BRK_CODE : push_data;

    rxq_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .push_req   (push_valid | brk_evt),
        .pop_req    (pop),
        .push_ready (push_ready),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .rd_addr    (rd_addr),
        .pop_take   (pop_take),
        .empty      (rx_empty),
        .full       (rx_full),
        .irq        (rx_irq)
    );

    rxq_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    rxq_stat #(.ENTRY_W(ENTRY_W), .DATA_W(DATA_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (pop_take),
        .entry    (rd_data),
        .pop_data (pop_data),
        .status   (rx_status)
    );
endmodule

// File: tb/sim_uart_rx_queue.sv
`timescale 1ns/1ps
module sim_uart_rx_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0, push_valid = 1'b0, brk_evt = 1'b0, pop = 1'b0;
    logic [11:0] push_data = '0;
    logic        push_ready, rx_empty, rx_full, rx_irq;
    logic [11:0] pop_data;
    logic [3:0]  rx_status;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    uart_rx_queue u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push_valid(push_valid),
        .push_data(push_data), .push_ready(push_ready), .brk_evt(brk_evt),
        .pop(pop), .pop_data(pop_data), .rx_status(rx_status),
        .rx_empty(rx_empty), .rx_full(rx_full), .rx_irq(rx_irq)
    );

    // stimulus: en pv pd brk pop | expected after edge: rdy emp ful irq pdat stat
    localparam int NV = 14;
    localparam logic [35:0] VEC [NV] = '{
        {1'b0,1'b1,12'h041,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b1,12'h000,4'h0}, // R3 R7
        {1'b0,1'b1,12'h042,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b1,12'h000,4'h0}, // R4
        {1'b0,1'b0,12'h000,1'b0,1'b1, 1'b1,1'b1,1'b0,1'b0,12'h041,4'h0}, // R5 R7
        {1'b0,1'b1,12'h1A5,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b1,12'h041,4'h0}, // R3
        {1'b0,1'b0,12'h000,1'b0,1'b1, 1'b1,1'b1,1'b0,1'b0,12'h1A5,4'h1}, // R5
        {1'b0,1'b0,12'h000,1'b1,1'b0, 1'b0,1'b0,1'b1,1'b1,12'h1A5,4'h1}, // R8
        {1'b0,1'b0,12'h000,1'b0,1'b1, 1'b1,1'b1,1'b0,1'b0,12'h400,4'h4}, // R8 R5
        {1'b0,1'b1,12'h055,1'b1,1'b0, 1'b0,1'b0,1'b1,1'b1,12'h400,4'h4}, // R8 priority
        {1'b0,1'b0,12'h000,1'b0,1'b1, 1'b1,1'b1,1'b0,1'b0,12'h400,4'h4}, // R8
        {1'b1,1'b1,12'h077,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0,12'h400,4'h4}, // R9
        {1'b1,1'b0,12'h000,1'b0,1'b1, 1'b1,1'b1,1'b0,1'b0,12'h041,4'h0}, // R6 R9
        {1'b1,1'b1,12'h061,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b1,12'h041,4'h0}, // R2 R7
        {1'b1,1'b1,12'h262,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b1,12'h061,4'h0}, // R11
        {1'b1,1'b0,12'h000,1'b0,1'b1, 1'b1,1'b1,1'b0,1'b0,12'h262,4'h2}  // R5 R7
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic en, input logic pv, input logic [11:0] pd,
                        input logic bk, input logic pp);
        fifo_en = en; push_valid = pv; push_data = pd; brk_evt = bk; pop = pp;
        @(posedge clk);
        @(negedge clk);
        push_valid = 1'b0; brk_evt = 1'b0; pop = 1'b0;
    endtask

    function automatic logic [31:0] outs();
        return {push_ready, rx_empty, rx_full, rx_irq, pop_data, rx_status};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", outs(), {1'b1,1'b1,1'b0,1'b0,12'h000,4'h0});

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][35], VEC[i][34], VEC[i][33:22], VEC[i][21], VEC[i][20]);
            chk($sformatf("vector %0d (R2-table)", i), outs(), {12'h0, VEC[i][19:0]});
        end

        // R2 R10: fill 16 starting at read position 2, wrap through slot 0
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 1'b1, 12'h010 + 12'(i), 1'b0, 1'b0);
            if (i == 14) chk("R2 not full at 15", {30'h0, rx_full, push_ready}, 32'h1);
            if (i == 15) chk("R2 full at 16", {30'h0, rx_full, push_ready}, 32'h2);
        end
        // R4: dropped push while full
        step(1'b1, 1'b1, 12'h0FF, 1'b0, 1'b0);
        chk("R4 full unchanged", {30'h0, rx_full, push_ready}, 32'h2);
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 1'b0, 12'h000, 1'b0, 1'b1);
            chk("R10 order", {20'h0, pop_data}, 32'h010 + i);
        end
        chk("R7 empty after drain", {30'h0, rx_empty, rx_irq}, 32'h2);

        // R9: flush mid-fill, then empty pop reads slot 0 (holds 0x01E)
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 12'h0A1 + 12'(i), 1'b0, 1'b0);
        chk("R9 pre-flush", {29'h0, rx_empty, rx_full, rx_irq}, 32'h1);
        step(1'b0, 1'b0, 12'h000, 1'b0, 1'b1);
        chk("R9 flushed flags", {28'h0, rx_empty, rx_full, rx_irq, push_ready}, 32'h9);
        chk("R9 pop ignored", {20'h0, pop_data}, 32'h01F);
        step(1'b0, 1'b0, 12'h000, 1'b0, 1'b1);
        chk("R6 empty pop slot 0", {20'h0, pop_data}, 32'h01E);
        chk("R6 still empty", {31'h0, rx_empty}, 32'h1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule